// File: doc/BRIEF.md
# TFT Panel Sync Timing Generator

This block derives every control strobe a 240x320 TFT panel needs from one pixel clock. All strobes are built on a common line period of `LINE_CLKS` pixel clocks. By default that period is the pixel clock rate divided by the refresh rate and by the number of lines per frame, using integer division: 6 MHz / 60 / 329 gives 303 clocks. A frame holds 320 visible lines plus 9 blanking lines, and a visible line carries 240 pixels.

The block drives five outputs:

- a one-clock line pulse;
- a one-clock per-line start pulse;
- a frame pulse that stays high for two lines;
- an active-low data window, 248 clocks wide (the 240 pixels plus 8), once per line;
- a polarity signal that inverts on every line.

Raising `enable` brings the trains up in a fixed staggered order so that they keep a known phase to each other. The polarity train starts first. The line train starts once the polarity count has passed 11. The frame, start and window trains start together once the line count has reached 3. Dropping `enable` stops every train. The stage code, the line index within the frame and the line-clock count are visible on debug pins.

Top module: `tft_sync_gen`

## Requirements
- R1: While reset is held and after it is released with `enable` low, `line_pulse`, `frame_pulse`, `start_pulse` and `polarity` are 0, `window_n` is 1, and `dbg_stage`, `dbg_line_idx` and `dbg_line_clk` are 0.
- R2: Count t as the number of rising edges after the edge that first samples `enable` high, so that t = 0 at that edge. `polarity` is high when t >= 1 and ((t-1) mod 2L) < L, where L is `LINE_CLKS`, and low otherwise. It therefore inverts every L clocks.
- R3: `line_pulse` is high for exactly one clock in every L, first at t = 15. The polarity count has then passed 11 and the stage has changed one clock before the train starts. `dbg_line_clk` equals (t-15) mod L from t = 15 and is 0 before.
- R4: `frame_pulse` is high while u = t-20 satisfies u >= 0 and (u mod (L*F)) < 2L, where F is the number of visible lines plus the number of blanking lines. It is therefore two lines wide and repeats every F lines.
- R5: `start_pulse` is high for one clock when u >= 0 and u mod L = 0. Its first pulse comes 5 clocks after the first line pulse, in the same clock as the frame pulse rises.
- R6: `window_n` is 0 when u >= 0 and (u mod L) < W, and 1 otherwise. W is the pixels per line plus 8 (default 248).
- R7: `dbg_stage` reads 0 when idle, 1 from t = 0 (polarity only), 2 from t = 14 (line train armed) and 3 from t = 19 (all trains armed).
- R8: `dbg_line_idx` equals (u / L) mod F for u >= 0 and 0 before. It is 0 during the line in which the frame pulse rises.
- R9: When `enable` is sampled low, all strobes return to the R1 levels and `dbg_stage` reads 0 after that same edge. They stay there while `enable` is low. A later rise of `enable` restarts the whole sequence from t = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; starts the staged bring-up, low stops all trains |
| line_pulse | output | 1 | One-clock pulse per line |
| frame_pulse | output | 1 | High for the first two lines of each frame |
| start_pulse | output | 1 | One-clock pulse at the start of each line |
| window_n | output | 1 | Active-low data window, W clocks per line |
| polarity | output | 1 | Line-alternating polarity |
| dbg_stage | output | 2 | Bring-up stage: 0 idle, 1 polarity, 2 line, 3 all |
| dbg_line_idx | output | $clog2(F) | Line index within the frame |
| dbg_line_clk | output | $clog2(L) | Clock count within the line train |

## Verification
On every cycle, the assertions check the following:

- the line, frame, start and window strobes never appear before their bring-up stage;
- a low `enable` clears every output on the next edge;
- the start and line pulses are one clock wide, and the frame and window strobes are at least two clocks wide;
- a polarity level never lasts longer than one line.

Only the bench's scenarios can show the exact phases between the trains:

- the 15- and 20-clock bring-up offsets;
- the exact frame repeat over two full frames;
- the line index wrapping at the frame boundary;
- a clean restart after the enable is dropped in mid-frame or during bring-up.

// File: rtl/tft_sync_pkg.sv
package tft_sync_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POL  = 2'd1,
    ST_LINE = 2'd2,
    ST_ALL  = 2'd3
  } tft_stage_e;

endpackage

// File: rtl/tft_pulse_timer.sv
// Free-running period counter with a programmable active window at the
// start of each period. Counting begins at zero on the first enabled edge.
module tft_pulse_timer #(
  parameter int PERIOD      = 4,
  parameter int WIDTH       = 1,
  parameter bit ACTIVE_HIGH = 1'b1,
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic          running,
  output logic [CW-1:0] cnt,
  output logic          out
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] WID  = CW'(WIDTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!run) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!running) begin
      running <= 1'b1;
      cnt     <= '0;
    end else begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  logic in_window;
  assign in_window = running && (cnt < WID);

  generate
    if (ACTIVE_HIGH) begin : g_hi
      assign out = in_window;
    end else begin : g_lo
      assign out = !in_window;
    end
  endgenerate

endmodule

// File: rtl/tft_start_seq.sv
// Staged bring-up: polarity train first, then the line train once the
// polarity count passes its threshold, then the remaining trains once the
// line count reaches its threshold.
module tft_start_seq
  import tft_sync_pkg::*;
#(
  parameter int PCW      = 4,
  parameter int LCW      = 4,
  parameter int POL_ARM  = 11,
  parameter int LINE_ARM = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           pol_running,
  input  logic [PCW-1:0] pol_cnt,
  input  logic           line_running,
  input  logic [LCW-1:0] line_cnt,
  output tft_stage_e     stage
);

  localparam logic [PCW-1:0] POL_T  = PCW'(POL_ARM);
  localparam logic [LCW-1:0] LINE_T = LCW'(LINE_ARM);

  tft_stage_e stage_nxt;

  always_comb begin
    stage_nxt = stage;
    if (!enable) begin
      stage_nxt = ST_IDLE;
    end else begin
      case (stage)
        ST_IDLE: stage_nxt = ST_POL;
        ST_POL:  if (pol_running && (pol_cnt > POL_T)) stage_nxt = ST_LINE;
        ST_LINE: if (line_running && (line_cnt >= LINE_T)) stage_nxt = ST_ALL;
        default: stage_nxt = ST_ALL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= ST_IDLE;
    else        stage <= stage_nxt;
  end

endmodule

// File: rtl/tft_sync_gen.sv
module tft_sync_gen
  import tft_sync_pkg::*;
#(
  parameter int PCLK_HZ           = 6_000_000,
  parameter int REFRESH_HZ        = 60,
  parameter int VIS_LINES         = 320,
  parameter int BLANK_LINES       = 9,
  parameter int H_PIXELS          = 240,
  parameter int WIN_EXTRA         = 8,
  parameter int FRAME_PULSE_LINES = 2,
  parameter int POL_ARM           = 11,
  parameter int LINE_ARM          = 3,
  parameter int LINE_CLKS         = PCLK_HZ / REFRESH_HZ / (VIS_LINES + BLANK_LINES),
  localparam int FRAME_LINES      = VIS_LINES + BLANK_LINES,
  localparam int IW               = (FRAME_LINES > 2) ? $clog2(FRAME_LINES) : 1,
  localparam int LCW              = (LINE_CLKS > 2) ? $clog2(LINE_CLKS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  output logic           line_pulse,
  output logic           frame_pulse,
  output logic           start_pulse,
  output logic           window_n,
  output logic           polarity,
  output logic [1:0]     dbg_stage,
  output logic [IW-1:0]  dbg_line_idx,
  output logic [LCW-1:0] dbg_line_clk
);

  localparam int WINDOW_CLKS = H_PIXELS + WIN_EXTRA;
  localparam int FRAME_CLKS  = LINE_CLKS * FRAME_LINES;
  localparam int POL_PERIOD  = 2 * LINE_CLKS;
  localparam int PCW         = $clog2(POL_PERIOD);
  localparam int FCW         = $clog2(FRAME_CLKS);
  localparam logic [LCW-1:0] LAST_CLK  = LCW'(LINE_CLKS - 1);
  localparam logic [IW-1:0]  LAST_LINE = IW'(FRAME_LINES - 1);

  tft_stage_e stage;
  logic run_pol, run_line, run_rest;

  assign run_pol  = enable && (stage != ST_IDLE);
  assign run_line = enable && ((stage == ST_LINE) || (stage == ST_ALL));
  assign run_rest = enable && (stage == ST_ALL);

  logic           pol_running, line_running, start_running;
  logic [PCW-1:0] pol_cnt;
  logic [LCW-1:0] line_cnt, start_cnt;
  logic           frame_running_unused, win_running_unused;
  logic [FCW-1:0] frame_cnt_unused;
  logic [LCW-1:0] win_cnt_unused;

  tft_start_seq #(
    .PCW(PCW), .LCW(LCW), .POL_ARM(POL_ARM), .LINE_ARM(LINE_ARM)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .pol_running(pol_running), .pol_cnt(pol_cnt),
    .line_running(line_running), .line_cnt(line_cnt),
    .stage(stage)
  );

  tft_pulse_timer #(.PERIOD(POL_PERIOD), .WIDTH(LINE_CLKS), .ACTIVE_HIGH(1'b1)) u_pol (
    .clk(clk), .rst_n(rst_n), .run(run_pol),
    .running(pol_running), .cnt(pol_cnt), .out(polarity)
  );

  tft_pulse_timer #(.PERIOD(LINE_CLKS), .WIDTH(1), .ACTIVE_HIGH(1'b1)) u_line (
    .clk(clk), .rst_n(rst_n), .run(run_line),
    .running(line_running), .cnt(line_cnt), .out(line_pulse)
  );

  tft_pulse_timer #(.PERIOD(FRAME_CLKS), .WIDTH(FRAME_PULSE_LINES * LINE_CLKS),
                    .ACTIVE_HIGH(1'b1)) u_frame (
    .clk(clk), .rst_n(rst_n), .run(run_rest),
    .running(frame_running_unused), .cnt(frame_cnt_unused), .out(frame_pulse)
  );

  tft_pulse_timer #(.PERIOD(LINE_CLKS), .WIDTH(1), .ACTIVE_HIGH(1'b1)) u_start (
    .clk(clk), .rst_n(rst_n), .run(run_rest),
    .running(start_running), .cnt(start_cnt), .out(start_pulse)
  );

  tft_pulse_timer #(.PERIOD(LINE_CLKS), .WIDTH(WINDOW_CLKS), .ACTIVE_HIGH(1'b0)) u_win (
    .clk(clk), .rst_n(rst_n), .run(run_rest),
    .running(win_running_unused), .cnt(win_cnt_unused), .out(window_n)
  );

  // Line index follows the start-pulse train, wrapping once per frame.
  logic [IW-1:0] line_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_idx <= '0;
    end else if (!run_rest) begin
      line_idx <= '0;
    end else if (start_running && (start_cnt == LAST_CLK)) begin
      line_idx <= (line_idx == LAST_LINE) ? '0 : line_idx + 1'b1;
    end
  end

  assign dbg_stage    = stage;
  assign dbg_line_idx = line_idx;
  assign dbg_line_clk = line_cnt;

endmodule

// File: rtl/tft_sync_gen_chk.sv
module tft_sync_gen_chk #(
  parameter int LINE_CLKS = 303
) (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       line_pulse,
  input logic       frame_pulse,
  input logic       start_pulse,
  input logic       window_n,
  input logic       polarity,
  input logic [1:0] dbg_stage
);

  // Length of the current polarity level while the block is running.
  logic pol_q;
  int   same_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q    <= 1'b0;
      same_cnt <= 0;
    end else if (dbg_stage == 2'd0) begin
      pol_q    <= polarity;
      same_cnt <= 0;
    end else begin
      pol_q    <= polarity;
      same_cnt <= (polarity == pol_q) ? same_cnt + 1 : 1;
    end
  end

  a_r2_pol_run_len: assert property (@(posedge clk) disable iff (!rst_n)
    same_cnt <= LINE_CLKS);

  a_r3_line_gated: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse |-> dbg_stage[1]);

  a_r3_line_single: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse |=> !line_pulse);

  a_r4_frame_two_clk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_pulse) |=> frame_pulse);

  a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  a_r6_window_two_clk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(window_n) |=> !window_n);

  a_r7_rest_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pulse || start_pulse || !window_n) |-> (dbg_stage == 2'd3));

  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!line_pulse && !frame_pulse && !start_pulse && window_n &&
                 !polarity && (dbg_stage == 2'd0)));

endmodule

bind tft_sync_gen tft_sync_gen_chk #(.LINE_CLKS(LINE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .line_pulse(line_pulse), .frame_pulse(frame_pulse),
  .start_pulse(start_pulse), .window_n(window_n),
  .polarity(polarity), .dbg_stage(dbg_stage)
);

// File: tb/sim_tft_sync_gen.sv
`timescale 1ns/1ps
module sim_tft_sync_gen;

  localparam int L    = 40;
  localparam int VIS  = 10;
  localparam int BLK  = 3;
  localparam int F    = VIS + BLK;
  localparam int HPIX = 20;
  localparam int W    = HPIX + 8;
  localparam int IW   = $clog2(F);
  localparam int LCW  = $clog2(L);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic line_pulse, frame_pulse, start_pulse, window_n, polarity;
  logic [1:0]     dbg_stage;
  logic [IW-1:0]  dbg_line_idx;
  logic [LCW-1:0] dbg_line_clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tft_sync_gen #(
    .VIS_LINES(VIS), .BLANK_LINES(BLK), .H_PIXELS(HPIX), .LINE_CLKS(L)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .line_pulse(line_pulse), .frame_pulse(frame_pulse),
    .start_pulse(start_pulse), .window_n(window_n), .polarity(polarity),
    .dbg_stage(dbg_stage), .dbg_line_idx(dbg_line_idx), .dbg_line_clk(dbg_line_clk)
  );

  task automatic cmp(input string tag, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, name, act, exp, $time);
    end
  endtask

  // Expected outputs t clocks after the first edge that sampled enable high;
  // t < 0 means idle.
  task automatic check_at(input int t, input string tag_idle);
    int u;
    u = t - 20;
    if (t < 0) begin
      cmp(tag_idle, "polarity",    int'(polarity), 0);
      cmp(tag_idle, "line_pulse",  int'(line_pulse), 0);
      cmp(tag_idle, "frame_pulse", int'(frame_pulse), 0);
      cmp(tag_idle, "start_pulse", int'(start_pulse), 0);
      cmp(tag_idle, "window_n",    int'(window_n), 1);
      cmp(tag_idle, "stage",       int'(dbg_stage), 0);
      cmp(tag_idle, "line_idx",    int'(dbg_line_idx), 0);
      cmp(tag_idle, "line_clk",    int'(dbg_line_clk), 0);
    end else begin
      cmp("R2", "polarity", int'(polarity), (t >= 1 && ((t - 1) % (2 * L)) < L) ? 1 : 0);
      cmp("R3", "line_pulse", int'(line_pulse), (t >= 15 && ((t - 15) % L) == 0) ? 1 : 0);
      cmp("R3", "line_clk", int'(dbg_line_clk), (t >= 15) ? ((t - 15) % L) : 0);
      cmp("R4", "frame_pulse", int'(frame_pulse), (u >= 0 && (u % (L * F)) < 2 * L) ? 1 : 0);
      cmp("R5", "start_pulse", int'(start_pulse), (u >= 0 && (u % L) == 0) ? 1 : 0);
      cmp("R6", "window_n", int'(window_n), (u >= 0 && (u % L) < W) ? 0 : 1);
      cmp("R7", "stage", int'(dbg_stage), (t >= 19) ? 3 : (t >= 14) ? 2 : 1);
      cmp("R8", "line_idx", int'(dbg_line_idx), (u >= 0) ? ((u / L) % F) : 0);
    end
  endtask

  // R1: reset levels, then idle with enable low.
  task automatic t_reset_state();
    rst_n = 1'b0;
    enable = 1'b0;
    repeat (3) @(negedge clk);
    check_at(-1, "R1");
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check_at(-1, "R1");
    end
  endtask

  // R2-R8: staged bring-up then more than two full frames.
  task automatic t_two_frames();
    enable = 1'b1;
    for (int t = 0; t < 20 + 2 * L * F + 3 * L; t++) begin
      @(negedge clk);
      check_at(t, "R1");
    end
  endtask

  // R9: drop enable mid-frame, stay idle, then restart from the beginning.
  task automatic t_disable_restart();
    enable = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check_at(-1, "R9");
    end
    enable = 1'b1;
    for (int t = 0; t < 20 + 3 * L; t++) begin
      @(negedge clk);
      check_at(t, "R9");
    end
  endtask

  // R9 and R3: enable dropped during bring-up before the line train arms.
  task automatic t_abort_bringup();
    enable = 1'b0;
    @(negedge clk);
    check_at(-1, "R9");
    enable = 1'b1;
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      check_at(t, "R9");
    end
    enable = 1'b0;
    for (int i = 0; i < 2 * L; i++) begin
      @(negedge clk);
      check_at(-1, "R9");
    end
    enable = 1'b1;
    for (int t = 0; t < 2 * L + 20; t++) begin
      @(negedge clk);
      check_at(t, "R3");
    end
  endtask

  initial begin
    t_reset_state();
    t_two_frames();
    t_disable_restart();
    t_abort_bringup();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule